// File: doc/BRIEF.md
# Dual-Ratio Alternating Frequency Divider

This block sits ahead of the slope counter of a low-frequency waveform generator. A fast, gated square wave reaches it as a one-cycle enable (`tick_en`), and each enabled cycle is one input event. An 8-bit counter divides these events by a ratio taken from the host. To divide by N, the counter starts at 256 − N and fires on overflow, so it gives one output pulse per N events. On the same edge it restarts from a fresh preload.

The divider keeps two ratios: one for the rising slope of the generated waveform and one for the falling slope. After a fixed group of output pulses (1000 by default), it swaps from one ratio to the other, so the output pulse rate alternates between two values. The host writes new ratios into a shadow stage. A host clear moves them into the working stage, puts the divider back at the start of a rising slope, and is passed one cycle later to the downstream counter. Every output pulse is widened to a fixed number of clock cycles. The block has no data stream, so all of its pins are plain control and status lines with no valid/ready handshake.

Top module: `alt_ratio_divider`

## Requirements
- R1: After `rst_n` goes low, `pulse_out`, `slope_down` and `clear_out` are 0, and both working ratios are 50. A divider started by a host clear without any write therefore fires every 50 events.
- R2: With working ratio N, the counter is preloaded with 256 − N. A rise of `pulse_out` follows the clock edge that takes the Nth enabled cycle counted from the previous fire or clear. Cycles with `tick_en` low do not advance the count.
- R3: `slope_down` is 0 on a rising slope and 1 on a falling slope. On the edge that produces the last pulse of a group of `PULSES_PER_SLOPE`, it toggles and the other ratio is preloaded. Pulses on a rising slope use the up ratio and pulses on a falling slope use the down ratio.
- R4: After a host clear, the divider is on a rising slope with its pulse group count at zero, and the counter is preloaded from the up ratio that was just committed.
- R5: `wr_up` / `wr_dn` load `wr_ratio` into the shadow up / down ratio only. Pulse timing stays the same until the next `host_clear` copies the shadow values into the working ratios.
- R6: A ratio below `RATIO_MIN` (10) is committed as 10. A ratio above `RATIO_MAX` (90) is committed as 90.
- R7: Each fire drives `pulse_out` high for exactly `STRETCH` (4) clock cycles, starting on the fire edge, unless a clear cuts it short.
- R8: `clear_out` equals `host_clear` delayed by one clock cycle.
- R9: On a cycle with `host_clear` high, `tick_en` is ignored. After that edge, `pulse_out` is 0 and `slope_down` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_clear | input | 1 | Synchronous host clear; commits the shadow ratios and restarts the divider |
| tick_en | input | 1 | One input event per cycle high (the gated square wave) |
| wr_up | input | 1 | Write `wr_ratio` into the shadow up ratio |
| wr_dn | input | 1 | Write `wr_ratio` into the shadow down ratio |
| wr_ratio | input | CNT_W | Ratio value to write |
| pulse_out | output | 1 | Stretched divider output pulse |
| slope_down | output | 1 | 0 on a rising slope, 1 on a falling slope |
| clear_out | output | 1 | `host_clear` delayed one cycle, sent to the downstream counter |

## Verification
The bench builds the block with `PULSES_PER_SLOPE` = 8 instead of 1000. This lets every run cross several slope swaps with ratios up to 90 in a few thousand cycles, so the alternation, the preload taken at the swap and the first pulse after each swap are all observed. The counter width, the stretch of 4 and the 10/90 limits keep their default values. Out-of-range writes of 3 and 250 therefore reach the clamp, and a mid-run write shows that the shadow stage holds new ratios back until a clear.

// File: rtl/adiv_pkg.sv
package adiv_pkg;
  typedef enum logic {
    SLOPE_UP   = 1'b0,
    SLOPE_DOWN = 1'b1
  } slope_e;

  function automatic slope_e other_slope(input slope_e s);
    return (s == SLOPE_UP) ? SLOPE_DOWN : SLOPE_UP;
  endfunction
endpackage

// File: rtl/adiv_ratio_bank.sv
module adiv_ratio_bank #(
  parameter int W     = 8,
  parameter int LO    = 10,
  parameter int HI    = 90,
  parameter int DEF   = 50
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         host_clear,
  input  logic         wr_up,
  input  logic         wr_dn,
  input  logic [W-1:0] wr_ratio,
  output logic [W-1:0] act_up,
  output logic [W-1:0] act_dn,
  output logic [W-1:0] nxt_up
);
  logic [W-1:0] sh_up, sh_dn;

  function automatic logic [W-1:0] clampr(input logic [W-1:0] v);
    if (v < W'(LO)) return W'(LO);
    if (v > W'(HI)) return W'(HI);
    return v;
  endfunction

  // Shadow stage: written by the host at any time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_up <= W'(DEF);
      sh_dn <= W'(DEF);
    end else begin
      if (wr_up) sh_up <= wr_ratio;
      if (wr_dn) sh_dn <= wr_ratio;
    end
  end

  // Working stage: committed only on host clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_up <= W'(DEF);
      act_dn <= W'(DEF);
    end else if (host_clear) begin
      act_up <= clampr(sh_up);
      act_dn <= clampr(sh_dn);
    end
  end

  // Value being committed, used by the counter preload on the clear edge
  assign nxt_up = clampr(sh_up);
endmodule

// File: rtl/adiv_slope_counter.sv
module adiv_slope_counter
  import adiv_pkg::*;
#(
  parameter int W   = 8,
  parameter int PPS = 1000,
  parameter int DEF = 50
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         host_clear,
  input  logic         tick_en,
  input  logic [W-1:0] act_up,
  input  logic [W-1:0] act_dn,
  input  logic [W-1:0] nxt_up,
  output logic         fire,
  output slope_e       slope
);
  localparam int PW = (PPS > 1) ? $clog2(PPS) : 1;

  logic [W-1:0]  cnt;
  logic [PW-1:0] grp;
  logic          last_in_grp;
  slope_e        next_slope;

  assign fire        = tick_en && !host_clear && (&cnt);
  assign last_in_grp = (grp == PW'(PPS - 1));
  assign next_slope  = last_in_grp ? other_slope(slope) : slope;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= W'(0) - W'(DEF);
      grp   <= '0;
      slope <= SLOPE_UP;
    end else if (host_clear) begin
      cnt   <= W'(0) - nxt_up;
      grp   <= '0;
      slope <= SLOPE_UP;
    end else if (fire) begin
      grp   <= last_in_grp ? '0 : grp + PW'(1);
      slope <= next_slope;
      cnt   <= W'(0) - ((next_slope == SLOPE_UP) ? act_up : act_dn);
    end else if (tick_en) begin
      cnt <= cnt + W'(1);
    end
  end
endmodule

// File: rtl/adiv_stretch.sv
module adiv_stretch #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic fire,
  output logic out
);
  localparam int SW = $clog2(LEN + 1);
  logic [SW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           left <= '0;
    else if (clear)       left <= '0;
    else if (fire)        left <= SW'(LEN);
    else if (left != '0)  left <= left - SW'(1);
  end

  assign out = (left != '0);
endmodule

// File: rtl/alt_ratio_divider.sv
module alt_ratio_divider
  import adiv_pkg::*;
#(
  parameter int CNT_W            = 8,
  parameter int PULSES_PER_SLOPE = 1000,
  parameter int STRETCH          = 4,
  parameter int RATIO_MIN        = 10,
  parameter int RATIO_MAX        = 90,
  parameter int RATIO_DEF        = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_clear,
  input  logic             tick_en,
  input  logic             wr_up,
  input  logic             wr_dn,
  input  logic [CNT_W-1:0] wr_ratio,
  output logic             pulse_out,
  output logic             slope_down,
  output logic             clear_out
);
  logic [CNT_W-1:0] act_up, act_dn, nxt_up;
  logic             fire;
  slope_e           slope;

  adiv_ratio_bank #(
    .W(CNT_W), .LO(RATIO_MIN), .HI(RATIO_MAX), .DEF(RATIO_DEF)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .host_clear(host_clear),
    .wr_up(wr_up), .wr_dn(wr_dn), .wr_ratio(wr_ratio),
    .act_up(act_up), .act_dn(act_dn), .nxt_up(nxt_up)
  );

  adiv_slope_counter #(
    .W(CNT_W), .PPS(PULSES_PER_SLOPE), .DEF(RATIO_DEF)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .host_clear(host_clear), .tick_en(tick_en),
    .act_up(act_up), .act_dn(act_dn), .nxt_up(nxt_up),
    .fire(fire), .slope(slope)
  );

  adiv_stretch #(.LEN(STRETCH)) u_str (
    .clk(clk), .rst_n(rst_n), .clear(host_clear), .fire(fire), .out(pulse_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clear_out <= 1'b0;
    else        clear_out <= host_clear;
  end

  assign slope_down = (slope == SLOPE_DOWN);
endmodule

// File: rtl/adiv_checker.sv
module adiv_checker #(
  parameter int STRETCH = 4
) (
  input logic clk,
  input logic rst_n,
  input logic host_clear,
  input logic tick_en,
  input logic pulse_out,
  input logic slope_down,
  input logic clear_out
);
  logic [7:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hi_len <= '0;
    else if (!pulse_out) hi_len <= '0;
    else if (hi_len != 8'hFF) hi_len <= hi_len + 8'd1;
  end

  // R8: clear_out trails host_clear by one cycle
  a_r8_clear_follow: assert property (@(posedge clk) disable iff (!rst_n)
    clear_out == $past(host_clear));

  // R9 and R4: a clear leaves the pulse low and the slope rising
  a_r9_clear_quiets: assert property (@(posedge clk) disable iff (!rst_n)
    host_clear |=> (!pulse_out && !slope_down));

  // R2: without an event no new pulse starts
  a_r2_no_tick_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !pulse_out) |=> !pulse_out);

  // R3: the slope only changes on a fire edge or on a clear
  a_r3_slope_moves_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(slope_down) |-> ($rose(pulse_out) || $past(host_clear)));

  // R7: an uninterrupted pulse lasts exactly STRETCH cycles
  a_r7_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pulse_out) && !$past(host_clear)) |-> (hi_len == 8'(STRETCH)));
endmodule

bind alt_ratio_divider adiv_checker #(.STRETCH(STRETCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_clear(host_clear), .tick_en(tick_en),
  .pulse_out(pulse_out), .slope_down(slope_down), .clear_out(clear_out)
);

// File: tb/test_alt_ratio_divider.sv
module test_alt_ratio_divider;
  localparam int W = 8;
  localparam int PPS = 8;
  localparam int STR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_clear = 1'b0, tick_en = 1'b0, wr_up = 1'b0, wr_dn = 1'b0;
  logic [W-1:0] wr_ratio = '0;
  logic pulse_out, slope_down, clear_out;

  int checks = 0, fails = 0;
  int exp_n[$];
  int exp_s[$];
  int pulses_seen = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  alt_ratio_divider #(
    .CNT_W(W), .PULSES_PER_SLOPE(PPS), .STRETCH(STR),
    .RATIO_MIN(10), .RATIO_MAX(90), .RATIO_DEF(50)
  ) i_alt_ratio_divider (
    .clk(clk), .rst_n(rst_n), .host_clear(host_clear), .tick_en(tick_en),
    .wr_up(wr_up), .wr_dn(wr_dn), .wr_ratio(wr_ratio),
    .pulse_out(pulse_out), .slope_down(slope_down), .clear_out(clear_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int clampv(input int v);
    if (v < 10) return 10;
    if (v > 90) return 90;
    return v;
  endfunction

  // Monitor: measure events between pulse rises, pulse width, and score
  initial begin
    int tick_cnt = 0, mark = 0, width = 0;
    bit prev_tick = 0, prev_clr = 0, prev_pulse = 0, cut = 0;
    forever begin
      @(negedge clk);
      if (prev_clr) begin
        tick_cnt = 0; mark = 0; cut = 1;
      end else if (prev_tick) begin
        tick_cnt++;
      end
      if (pulse_out && !prev_pulse) begin
        int n, s;
        pulses_seen++;
        width = 1; cut = 0;
        if (exp_n.size() == 0) begin
          check(0, "R2 unexpected pulse", tick_cnt - mark, 0);
        end else begin
          n = exp_n.pop_front();
          s = exp_s.pop_front();
          check(tick_cnt - mark == n, "R2/R3 events per pulse", tick_cnt - mark, n);
          check(int'(slope_down) == s, "R3 slope at pulse", int'(slope_down), s);
        end
        mark = tick_cnt;
      end else if (pulse_out) begin
        width++;
      end else if (prev_pulse && !cut) begin
        check(width == STR, "R7 pulse width", width, STR);
      end
      prev_pulse = pulse_out;
      prev_tick  = tick_en;
      prev_clr   = host_clear;
    end
  end

  task automatic write_ratios(input int up, input int dn);
    @(posedge clk); #1; tick_en = 0; wr_up = 1; wr_ratio = W'(up);
    @(posedge clk); #1; wr_up = 0; wr_dn = 1; wr_ratio = W'(dn);
    @(posedge clk); #1; wr_dn = 0;
  endtask

  task automatic do_clear();
    @(posedge clk); #1; host_clear = 1; tick_en = 1;  // R9: event ignored
    @(posedge clk); #1; host_clear = 0; tick_en = 0;
    @(negedge clk);
    check(clear_out == 1'b1, "R8 clear_out after clear", int'(clear_out), 1);
    check(pulse_out == 1'b0, "R9 pulse low after clear", int'(pulse_out), 0);
    check(slope_down == 1'b0, "R4 rising slope after clear", int'(slope_down), 0);
    @(negedge clk);
    check(clear_out == 1'b0, "R8 clear_out falls", int'(clear_out), 0);
  endtask

  // Driver: push expected pulses, then feed events until the scoreboard drains
  task automatic run(input int up, input int dn, input int npulse, input int mode,
                     input int mid_up, input int mid_dn);
    logic [7:0] lfsr = 8'hA5;
    int step = 0, guard = 0;
    for (int i = 0; i < npulse; i++) begin
      int s = ((i + 1) / PPS) % 2;
      int seg = (i / PPS) % 2;
      exp_n.push_back(seg == 0 ? clampv(up) : clampv(dn));
      exp_s.push_back(s);
    end
    pulses_seen = 0;
    while (exp_n.size() > 0 && guard < 20000) begin
      @(posedge clk); #1;
      guard++;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (mode)
        0: tick_en = 1;
        1: tick_en = guard[0];
        default: tick_en = lfsr[0];
      endcase
      wr_up = 0; wr_dn = 0;
      if (mid_up > 0 && pulses_seen >= 3 && step < 2) begin
        if (step == 0) begin wr_up = 1; wr_ratio = W'(mid_up); end
        else           begin wr_dn = 1; wr_ratio = W'(mid_dn); end
        step++;
      end
    end
    @(posedge clk); #1; tick_en = 0; wr_up = 0; wr_dn = 0;
    check(exp_n.size() == 0, "R2 all expected pulses seen", exp_n.size(), 0);
    exp_n.delete(); exp_s.delete();
    repeat (STR + 2) @(posedge clk);
  endtask

  initial begin
    #(8 * 150000);
    check(0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pulse_out == 0, "R1 reset pulse_out", int'(pulse_out), 0);
    check(slope_down == 0, "R1 reset slope_down", int'(slope_down), 0);
    check(clear_out == 0, "R1 reset clear_out", int'(clear_out), 0);
    @(posedge clk); #1; rst_n = 1;

    // R1: defaults of 50/50 with no write
    do_clear();
    run(50, 50, 20, 0, 0, 0);

    // R2 R3 R4: asymmetric ratios, gated events
    write_ratios(45, 55);
    do_clear();
    run(45, 55, 20, 1, 0, 0);

    // R5: mid-run write is held in the shadow stage
    write_ratios(20, 80);
    do_clear();
    run(20, 80, 18, 2, 70, 30);
    do_clear();
    run(70, 30, 10, 0, 0, 0);

    // R6: clamping of out-of-range ratios
    write_ratios(3, 250);
    do_clear();
    run(3, 250, 17, 2, 0, 0);

    // R9: clear in the middle of a run
    write_ratios(12, 88);
    do_clear();
    run(12, 88, 3, 0, 0, 0);
    do_clear();
    run(12, 88, 10, 0, 0, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule